// File: doc/BRIEF.md
# SDRAM Refresh Control and Interval Timer

This block holds the 32-bit refresh control word of an SDRAM controller. It also generates the periodic refresh requests that the command scheduler services. The word is written over a simple register port: a write strobe, an address-match select, 32 bits of write data with four byte enables, and combinational read data. The word holds a 16-bit refresh interval counted in DDR clock cycles, a self-refresh temperature-range bit, an auto self-refresh enable, a 3-bit partial-array self-refresh code and a master disable. The tRFC, tRP and tRCD timing values come in on input ports from the controller's other timing registers.

An interval timer counts the effective interval and reports each expiry to a pending-request counter. The counter keeps the refresh request high until the scheduler has acknowledged every outstanding expiry. The effective interval is the larger of the stored interval and a floor of 8*tRFC + tRP + tRCD + 20, so a small or zero setting cannot starve the scheduler.

Writing the option byte pulses an initialization request. The disable bit silences both refresh and initialization, while the traffic-permitted output stays high. A sticky error output flags partial-array codes that are reserved in LPDDR1 mode.

The timer state machine has three states. TM_START is the state after reset: it loads the counter and goes to TM_RUN, or to TM_HOLD if disabled. TM_RUN counts down. It reloads on a register write and on expiry, and goes to TM_HOLD when the disable bit is set. TM_HOLD freezes the counter. When the disable bit clears it reloads and returns to TM_RUN. The pending counter's state machine also has three states: PD_EMPTY, PD_PART and PD_FULL. An expiry moves it EMPTY to PART, and PART to FULL when the count reaches the limit. An acknowledge moves it FULL to PART, and PART to EMPTY when the count reaches zero. The disable bit forces PD_EMPTY from any state.

Top module: `rfsh_ctl_top`

## Requirements
- R1: After reset, every field of the word reads 0, rfsh_req, init_start and pasr_err are 0, and traffic_ok is 1 from the first clock edge after reset release.
- R2: A write (bus_wr and bus_sel) updates only the enabled byte lanes. Lane 0 holds interval bits 7:0. Lane 1 holds interval bits 15:8. Lane 3 holds bit 31 (disable), bit 29 (temperature range), bit 28 (auto self-refresh) and bits 26:24 (partial-array code). Lane 2 and bits 30, 27 and 23:16 ignore writes and read as 0. bus_rdata shows the word while bus_sel is 1 and 0 otherwise.
- R3: On every write, the stored interval becomes the larger of the interval after the lane merge and 8*t_rfc + t_rp + t_rcd + 20, using the timing inputs at the write edge.
- R4: After a write with the disable bit 0, rfsh_req rises on the (N+1)th rising edge after the write edge, where N is the effective interval. Expiries then repeat every N cycles.
- R5: The effective interval is recomputed at each reload, as the larger of the stored interval and the floor from the timing inputs present at that reload.
- R6: Expiries not yet acknowledged are counted up to 8, and further expiries are dropped. rfsh_req is high while the count is nonzero. Each rising edge with rfsh_ack high and rfsh_req high takes one off the count.
- R7: While bit 31 is 1, rfsh_req and init_start stay 0, the pending count is cleared and the timer is frozen, and traffic_ok stays 1. Clearing bit 31 restarts a full interval, as in R4.
- R8: init_start is high for one cycle after a write with byte enable 3 high and written bit 31 equal to 0. It stays 0 after writes that leave lane 3 disabled.
- R9: Bit 29 is stored as 0 whenever the resulting bit 28 is 1.
- R10: With mem_is_lp = 1, a write that leaves the partial-array code at 3, 4 or 7 sets pasr_err one cycle later. pasr_err then stays 1 until reset. With mem_is_lp = 0, every code is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DDR clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_sel | input | 1 | Address match for this register |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables |
| bus_rdata | output | 32 | Read data, 0 when not selected |
| mem_is_lp | input | 1 | 1 selects the LPDDR1 partial-array code table |
| t_rfc | input | RFC_W | Refresh cycle time in clocks |
| t_rp | input | RP_W | Precharge time in clocks |
| t_rcd | input | RCD_W | Activate-to-access time in clocks |
| rfsh_req | output | 1 | Refresh request, high while expiries are pending |
| rfsh_ack | input | 1 | Scheduler acknowledge, one per serviced refresh |
| init_start | output | 1 | One-cycle request for the initialization sequence |
| traffic_ok | output | 1 | Read and write traffic permitted |
| pasr_err | output | 1 | Sticky flag for a reserved partial-array code |

## Verification
The hardest state to reach from the ports is a saturated pending counter that the scheduler then drains. Nothing outside can see the count, so the bench must time its acknowledges exactly. It resets the timer phase with a disable-and-write pair, so the edge of every later expiry is known. It then waits out nine expiries with the acknowledge low and drains inside a window that no expiry can reach. The recomputed floor is reached in a similar way: the timing inputs change in the cycle of a seen expiry, and the gap after the next reload is measured. Seeded random writes with random byte enables and timing values exercise the lane merge, the floor and the option-byte rules against a bench model.

// File: rtl/rfsh_pkg.sv
`timescale 1ns/1ps
package rfsh_pkg;
    // Bit positions of the control word; the scheduler and software rely on these.
    localparam int INT_W      = 16;
    localparam int DIS_BIT    = 31;
    localparam int SRT_BIT    = 29;
    localparam int ASR_BIT    = 28;
    localparam int PASR_LSB   = 24;
    localparam int PASR_W     = 3;

    typedef enum logic [1:0] {
        TM_START = 2'd0,
        TM_RUN   = 2'd1,
        TM_HOLD  = 2'd2
    } tm_state_e;

    typedef enum logic [1:0] {
        PD_EMPTY = 2'd0,
        PD_PART  = 2'd1,
        PD_FULL  = 2'd2
    } pd_state_e;

    // Codes with no meaning in the LPDDR1 table
    function automatic logic lp_code_reserved(input logic [PASR_W-1:0] code);
        return (code == 3'd3) || (code == 3'd4) || (code == 3'd7);
    endfunction
endpackage

// File: rtl/rfsh_floor.sv
`timescale 1ns/1ps
module rfsh_floor
    import rfsh_pkg::*;
#(
    parameter int RFC_W     = 8,
    parameter int RP_W      = 4,
    parameter int RCD_W     = 4,
    parameter int FLOOR_ADD = 20
) (
    input  logic [RFC_W-1:0] t_rfc,
    input  logic [RP_W-1:0]  t_rp,
    input  logic [RCD_W-1:0] t_rcd,
    output logic [INT_W-1:0] floor_val
);
    localparam int SUM_W = INT_W + 2;
    localparam logic [SUM_W-1:0] LIMIT = SUM_W'({INT_W{1'b1}});

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = (SUM_W'(t_rfc) << 3) + SUM_W'(t_rp) + SUM_W'(t_rcd)
            + SUM_W'(FLOOR_ADD);
        floor_val = (sum > LIMIT) ? {INT_W{1'b1}} : sum[INT_W-1:0];
    end
endmodule

// File: rtl/rfsh_regfile.sv
`timescale 1ns/1ps
module rfsh_regfile
    import rfsh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    input  logic [3:0]        be,
    input  logic [INT_W-1:0]  floor_val,
    input  logic              mem_is_lp,
    output logic [INT_W-1:0]  interval_q,
    output logic              dis_q,
    output logic              reload_q,
    output logic              init_pulse_q,
    output logic              pasr_err_q,
    output logic              traffic_q,
    output logic [31:0]       rd_word
);
    logic              srt_q;
    logic              asr_q;
    logic [PASR_W-1:0] pasr_q;

    logic [INT_W-1:0]  merged_int;
    logic [INT_W-1:0]  lifted_int;
    logic              nxt_dis;
    logic              nxt_asr;
    logic              nxt_srt;
    logic [PASR_W-1:0] nxt_pasr;
    logic              pasr_bad;
    logic              unused_lanes;

    assign unused_lanes = ^{wdata[30], wdata[27], wdata[23:16], be[2]};

    // Lane merge, floor lift and option-byte rules
    always_comb begin
        merged_int = interval_q;
        if (be[0]) merged_int[7:0]  = wdata[7:0];
        if (be[1]) merged_int[15:8] = wdata[15:8];
        lifted_int = (merged_int < floor_val) ? floor_val : merged_int;

        nxt_dis  = be[3] ? wdata[DIS_BIT] : dis_q;
        nxt_asr  = be[3] ? wdata[ASR_BIT] : asr_q;
        nxt_srt  = (be[3] ? wdata[SRT_BIT] : srt_q) & ~nxt_asr;
        nxt_pasr = be[3] ? wdata[PASR_LSB +: PASR_W] : pasr_q;
        pasr_bad = mem_is_lp && lp_code_reserved(nxt_pasr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            interval_q   <= '0;
            dis_q        <= 1'b0;
            srt_q        <= 1'b0;
            asr_q        <= 1'b0;
            pasr_q       <= '0;
            reload_q     <= 1'b0;
            init_pulse_q <= 1'b0;
            pasr_err_q   <= 1'b0;
            traffic_q    <= 1'b0;
        end else begin
            traffic_q    <= 1'b1;
            reload_q     <= wr_en;
            init_pulse_q <= wr_en && be[3] && !nxt_dis;
            if (wr_en) begin
                interval_q <= lifted_int;
                dis_q      <= nxt_dis;
                srt_q      <= nxt_srt;
                asr_q      <= nxt_asr;
                pasr_q     <= nxt_pasr;
                if (pasr_bad) pasr_err_q <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_word                      = '0;
        rd_word[INT_W-1:0]           = interval_q;
        rd_word[DIS_BIT]             = dis_q;
        rd_word[SRT_BIT]             = srt_q;
        rd_word[ASR_BIT]             = asr_q;
        rd_word[PASR_LSB +: PASR_W]  = pasr_q;
    end
endmodule

// File: rtl/rfsh_timer.sv
`timescale 1ns/1ps
module rfsh_timer
    import rfsh_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dis,
    input  logic             reload,
    input  logic [INT_W-1:0] interval,
    input  logic [INT_W-1:0] floor_val,
    output logic             expire
);
    tm_state_e        st_q, st_d;
    logic [INT_W-1:0] cnt_q, cnt_d;
    logic [INT_W-1:0] eff;

    assign eff = (interval > floor_val) ? interval : floor_val;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TM_START;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TM_START: st_d = dis ? TM_HOLD : TM_RUN;
            TM_RUN:   if (dis) st_d = TM_HOLD;
            TM_HOLD:  if (!dis) st_d = TM_RUN;
            default:  st_d = TM_START;
        endcase
    end

    // Counter and expiry output
    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        unique case (st_q)
            TM_START: cnt_d = eff - INT_W'(1);
            TM_RUN: begin
                if (dis) begin
                    cnt_d = cnt_q;
                end else if (reload) begin
                    cnt_d = eff - INT_W'(1);
                end else if (cnt_q == '0) begin
                    expire = 1'b1;
                    cnt_d  = eff - INT_W'(1);
                end else begin
                    cnt_d = cnt_q - INT_W'(1);
                end
            end
            TM_HOLD:  if (!dis) cnt_d = eff - INT_W'(1);
            default:  cnt_d = '0;
        endcase
    end
endmodule

// File: rtl/rfsh_pending.sv
`timescale 1ns/1ps
module rfsh_pending
    import rfsh_pkg::*;
#(
    parameter int PEND_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dis,
    input  logic inc,
    input  logic ack,
    output logic req
);
    localparam int CW = $clog2(PEND_MAX + 1);
    localparam logic [CW-1:0] TOP = CW'(PEND_MAX);
    localparam logic [CW-1:0] ONE = CW'(1);

    pd_state_e      st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           dec;

    assign dec = ack && (st_q != PD_EMPTY);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PD_EMPTY;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state and count
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (dis) begin
            st_d  = PD_EMPTY;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                PD_EMPTY: if (inc) begin
                    cnt_d = ONE;
                    st_d  = (ONE == TOP) ? PD_FULL : PD_PART;
                end
                PD_PART: begin
                    if (inc && !dec) begin
                        cnt_d = cnt_q + ONE;
                        if (cnt_q + ONE == TOP) st_d = PD_FULL;
                    end else if (dec && !inc) begin
                        cnt_d = cnt_q - ONE;
                        if (cnt_q == ONE) st_d = PD_EMPTY;
                    end
                end
                PD_FULL: if (dec && !inc) begin
                    cnt_d = cnt_q - ONE;
                    st_d  = (cnt_q == ONE) ? PD_EMPTY : PD_PART;
                end
                default: begin
                    st_d  = PD_EMPTY;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // Output
    always_comb begin
        req = (st_q != PD_EMPTY) && !dis;
    end
endmodule

// File: rtl/rfsh_ctl_top.sv
`timescale 1ns/1ps
module rfsh_ctl_top
    import rfsh_pkg::*;
#(
    parameter int RFC_W     = 8,
    parameter int RP_W      = 4,
    parameter int RCD_W     = 4,
    parameter int FLOOR_ADD = 20,
    parameter int PEND_MAX  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_sel,
    input  logic [31:0]      bus_wdata,
    input  logic [3:0]       bus_be,
    output logic [31:0]      bus_rdata,
    input  logic             mem_is_lp,
    input  logic [RFC_W-1:0] t_rfc,
    input  logic [RP_W-1:0]  t_rp,
    input  logic [RCD_W-1:0] t_rcd,
    output logic             rfsh_req,
    input  logic             rfsh_ack,
    output logic             init_start,
    output logic             traffic_ok,
    output logic             pasr_err
);
    logic [INT_W-1:0] floor_val;
    logic [INT_W-1:0] interval_q;
    logic             init_dis_q;
    logic             reload_q;
    logic             expire;
    logic [31:0]      rd_word;
    logic             wr_en;

    assign wr_en     = bus_wr && bus_sel;
    assign bus_rdata = bus_sel ? rd_word : '0;

    rfsh_floor #(
        .RFC_W(RFC_W), .RP_W(RP_W), .RCD_W(RCD_W), .FLOOR_ADD(FLOOR_ADD)
    ) u_floor (
        .t_rfc(t_rfc), .t_rp(t_rp), .t_rcd(t_rcd), .floor_val(floor_val)
    );

    rfsh_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(bus_wdata),
        .be(bus_be), .floor_val(floor_val), .mem_is_lp(mem_is_lp),
        .interval_q(interval_q), .dis_q(init_dis_q), .reload_q(reload_q),
        .init_pulse_q(init_start), .pasr_err_q(pasr_err),
        .traffic_q(traffic_ok), .rd_word(rd_word)
    );

    rfsh_timer u_timer (
        .clk(clk), .rst_n(rst_n), .dis(init_dis_q), .reload(reload_q),
        .interval(interval_q), .floor_val(floor_val), .expire(expire)
    );

    rfsh_pending #(.PEND_MAX(PEND_MAX)) u_pend (
        .clk(clk), .rst_n(rst_n), .dis(init_dis_q), .inc(expire),
        .ack(rfsh_ack), .req(rfsh_req)
    );
endmodule

// File: rtl/rfsh_ctl_chk.sv
`timescale 1ns/1ps
module rfsh_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_sel,
    input logic [31:0] bus_wdata,
    input logic [3:0]  bus_be,
    input logic [31:0] bus_rdata,
    input logic        rfsh_req,
    input logic        rfsh_ack,
    input logic        init_start,
    input logic        traffic_ok,
    input logic        pasr_err,
    input logic        dis
);
    // R8
    init_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |-> $past(bus_wr && bus_sel && bus_be[3]));

    // R9
    srt_asr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |-> !(bus_rdata[29] && bus_rdata[28]));

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[30] == 1'b0) && (bus_rdata[27] == 1'b0)
        && (bus_rdata[23:16] == 8'h00));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pasr_err |=> pasr_err);

    // R7
    dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis |-> (!rfsh_req && !init_start));

    // R7
    traffic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        traffic_ok |=> traffic_ok);

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_req && !rfsh_ack
         && !(bus_wr && bus_sel && bus_be[3] && bus_wdata[31]))
        |=> rfsh_req);
endmodule

bind rfsh_ctl_top rfsh_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .rfsh_req(rfsh_req), .rfsh_ack(rfsh_ack), .init_start(init_start),
    .traffic_ok(traffic_ok), .pasr_err(pasr_err), .dis(init_dis_q)
);

// File: tb/rfsh_ctl_top_test.sv
`timescale 1ns/1ps
module rfsh_ctl_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_sel = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic        mem_is_lp = 1'b0;
    logic [7:0]  t_rfc = 8'd2;
    logic [3:0]  t_rp = 4'd3;
    logic [3:0]  t_rcd = 4'd3;
    logic        rfsh_req;
    logic        rfsh_ack = 1'b0;
    logic        init_start;
    logic        traffic_ok;
    logic        pasr_err;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    // bench model of the control word
    int   m_int = 0;
    bit   m_dis = 0, m_srt = 0, m_asr = 0, m_err = 0;
    bit [2:0] m_pasr = 0;

    always #2.5 clk = ~clk;

    rfsh_ctl_top uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .mem_is_lp(mem_is_lp), .t_rfc(t_rfc), .t_rp(t_rp), .t_rcd(t_rcd),
        .rfsh_req(rfsh_req), .rfsh_ack(rfsh_ack), .init_start(init_start),
        .traffic_ok(traffic_ok), .pasr_err(pasr_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int floor_f();
        return 8 * int'(t_rfc) + int'(t_rp) + int'(t_rcd) + 20;
    endfunction

    function automatic logic [31:0] exp_word();
        return {m_dis, 1'b0, m_srt, m_asr, 1'b0, m_pasr, 8'h00, m_int[15:0]};
    endfunction

    function automatic bit lp_bad(input bit [2:0] c);
        return (c == 3'd3) || (c == 3'd4) || (c == 3'd7);
    endfunction

    // write, update the model, check init pulse and error flag
    task automatic do_write(input logic [31:0] d, input logic [3:0] be);
        int  merged;
        bit  exp_init;
        merged = m_int;
        if (be[0]) merged = (merged & 32'hFF00) | int'(d[7:0]);
        if (be[1]) merged = (merged & 32'h00FF) | (int'(d[15:8]) << 8);
        m_int = (merged < floor_f()) ? floor_f() : merged;
        if (be[3]) begin
            m_dis  = d[31];
            m_asr  = d[28];
            m_srt  = d[29];
            m_pasr = d[26:24];
        end
        if (m_asr) m_srt = 0;
        if (mem_is_lp && lp_bad(m_pasr)) m_err = 1;
        exp_init = be[3] && !d[31];
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = 1'b1; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_sel = 1'b0; bus_be = '0;
        chk("R8 init_start after write", init_start, exp_init);
        chk("R10 pasr_err after write", pasr_err, m_err);
    endtask

    task automatic read_chk(input string req);
        @(negedge clk);
        bus_sel = 1'b1;
        #1;
        chk(req, bus_rdata, exp_word());
        bus_sel = 1'b0;
    endtask

    // counts negedges until rfsh_req is seen high
    task automatic wait_req(output int n);
        n = 0;
        while (!rfsh_req && n < 5000) begin
            @(negedge clk);
            n = n + 1;
        end
    endtask

    initial begin
        int n, g1, g2, k;
        bit seen;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        bus_sel = 1'b1; #1;
        chk("R1 word after reset", bus_rdata, 32'h0);
        bus_sel = 1'b0; #1;
        chk("R2 rdata unselected", bus_rdata, 32'h0);
        chk("R1 rfsh_req after reset", rfsh_req, 0);
        chk("R1 init_start after reset", init_start, 0);
        chk("R1 pasr_err after reset", pasr_err, 0);
        chk("R1 traffic_ok after reset", traffic_ok, 1);

        // R2 lane 2 and reserved bits ignored, no init pulse from lane 2
        do_write(32'hFFFF_FFFF, 4'b0100);
        read_chk("R2 lane 2 write ignored");
        // R3 small interval lifted to floor 42
        do_write(32'h0000_0005, 4'b0011);
        read_chk("R3 floor applied");
        chk("R3 floor value", m_int, 42);
        // R9 srt forced low with asr
        do_write(32'h3000_0000, 4'b1000);
        read_chk("R9 srt cleared when asr set");

        // R4 / R5 interval timing, ack held high
        rfsh_ack = 1'b1;
        do_write(32'h8000_0000, 4'b1000);
        do_write(32'h0000_0064, 4'b1011);
        wait_req(n);
        chk("R4 first request delay", n, 101);
        @(negedge clk); g1 = 1;
        while (!rfsh_req && g1 < 5000) begin @(negedge clk); g1 = g1 + 1; end
        chk("R4 repeat period", g1, 100);
        t_rfc = 8'd20;  // floor 186
        @(negedge clk); g1 = 1;
        while (!rfsh_req && g1 < 5000) begin @(negedge clk); g1 = g1 + 1; end
        chk("R5 period before reload with new inputs", g1, 100);
        @(negedge clk); g2 = 1;
        while (!rfsh_req && g2 < 5000) begin @(negedge clk); g2 = g2 + 1; end
        chk("R5 period after floor rise", g2, 186);
        t_rfc = 8'd2;

        // R6 saturation: interval 200, nine expiries with no ack
        rfsh_ack = 1'b0;
        do_write(32'h8000_0000, 4'b1000);
        do_write(32'h0000_00C8, 4'b1011);
        repeat (1810) @(negedge clk);
        chk("R6 request held without ack", rfsh_req, 1);
        k = 0;
        rfsh_ack = 1'b1;
        while (rfsh_req && k < 20) begin @(negedge clk); k = k + 1; end
        rfsh_ack = 1'b0;
        chk("R6 acks to drain saturated count", k, 8);

        // R7 disable
        do_write(32'h8000_0000, 4'b1000);
        chk("R7 traffic_ok while disabled", traffic_ok, 1);
        seen = 0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (rfsh_req || init_start) seen = 1;
        end
        chk("R7 no request while disabled", seen, 0);
        rfsh_ack = 1'b1;
        do_write(32'h0000_0000, 4'b1000);
        wait_req(n);
        chk("R7 full interval after re-enable", n, 201);
        rfsh_ack = 1'b0;
        // R8 no init pulse from interval-only write
        do_write(32'h0000_0080, 4'b0011);

        // R10 partial-array codes
        mem_is_lp = 1'b0;
        do_write(32'h0300_0000, 4'b1000);
        chk("R10 code 3 accepted in other mode", pasr_err, 0);
        mem_is_lp = 1'b1;
        do_write(32'h0500_0000, 4'b1000);
        chk("R10 code 5 valid in LPDDR1", pasr_err, 0);
        do_write(32'h0400_0000, 4'b1000);
        chk("R10 code 4 flagged", pasr_err, 1);
        do_write(32'h0000_0000, 4'b1000);
        chk("R10 error sticky", pasr_err, 1);
        read_chk("R2 word after option writes");

        // random writes against the model (R2 R3 R8 R9 R10)
        for (int i = 0; i < 60; i++) begin
            t_rfc     = 8'($urandom % 40);
            t_rp      = 4'($urandom % 16);
            t_rcd     = 4'($urandom % 16);
            mem_is_lp = 1'($urandom % 2);
            do_write($urandom, 4'($urandom % 16));
            read_chk("R2 random readback");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule